// File: doc/BRIEF.md
# Per-Block Code Parameter Sequencer

This block sits in front of a block-code encoder datapath. It is the piece that decides which code settings apply to each block. Software or an upstream producer writes one control word per block on a valid/ready control stream. The block keeps up to sixteen such words in an internal queue. Each word holds a block-length field and, in the variable variant, a check-count field. Each field sits in a byte-aligned slot, and the bits above the field inside its slot are ignored.

When the first symbol of a block is accepted on the data stream, the sequencer takes the oldest queued word. It then drives the total length, the data-symbol count and the check-symbol count of that block to the datapath, and holds these values for the rest of the block. The data stream's ready is held low while no block is open and no word is queued, so a block can never start without its settings. Every word is range-checked as it is accepted. A bad value raises a flag that stays high until reset.

A parameter picks the variant. In the variable variant, the check count comes from the word. In the fixed variant, the check count is a build-time constant and only the length field is present.

Top module: `blkparam_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, ctl_ready is 1, din_ready is 0 and ctl_bad is 0.
- R2: With the defaults, ctl_data is 16 bits wide. The block length is read from bits [7:0]. The check count is read from bits [12:8]. Bits [15:13] have no effect on any output.
- R3: The queue holds at most 16 words. ctl_ready is 0 exactly while 16 words are queued, and a word offered then is not taken.
- R4: din_ready is 1 exactly while a block is open or at least one word is queued. A word accepted at a clock edge makes din_ready 1 in the very next cycle.
- R5: In the variable variant, blk_n equals the length field, blk_r equals the check field, and blk_k equals (length − check) modulo 2^SYM_W.
- R6: In the fixed variant (VAR_R=0), blk_r equals RCHK_MAX and blk_k equals (length − RCHK_MAX) modulo 2^SYM_W.
- R7: A block starts on the first symbol accepted while no block is open, and it spans blk_k accepted symbols. blk_open is 1 from the cycle after that first symbol until the cycle after its last symbol. A blk_k of 0 or 1 gives a one-symbol block.
- R8: The block settings are driven from the cycle in which the first symbol is offered with din_ready high, and they do not change until the block ends.
- R9: ctl_bad rises in the cycle after a word is accepted in any of these cases: its length is below 4; or, in the variable variant, its check count is below 2 or above min(RCHK_MAX, 256). Once set, ctl_bad stays 1 until reset.
- R10: A synchronous reset (rst high) empties the queue, closes any open block and clears ctl_bad.
- R11: Words are used for blocks in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctl_valid | input | 1 | Control word offered |
| ctl_ready | output | 1 | Queue can take a control word |
| ctl_data | input | CW (16) | Control word: length slot low, check slot above it |
| din_valid | input | 1 | Data symbol offered by the upstream source |
| din_ready | output | 1 | Data symbol may be taken |
| blk_open | output | 1 | A block is in progress after its first symbol |
| blk_n | output | SYM_W (8) | Total symbols of the current block |
| blk_k | output | SYM_W (8) | Data symbols of the current block |
| blk_r | output | RW (5) | Check symbols of the current block |
| ctl_bad | output | 1 | Sticky out-of-range control flag |

## Verification
The embedded properties check the following on every cycle:
- the queue never overflows or underflows;
- an open block always has symbols left to take;
- the held settings never move while a block is open;
- ctl_bad never drops without a reset;
- ctl_bad only rises right after an accepted word.

Two things only the bench scenarios can show. One is that the settings are the correct ones: the right field slicing, the ignored padding, the wrapped data count, and the use of words in order. The other is that the stall lifts one cycle after a word arrives. The bench tracks both variants with a queue model in parallel, and it drives full-queue, starved-input, boundary-range and mid-run-reset cases.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } blk_state_e;

    // round a field width up to a whole number of bytes
    function automatic int pad8(input int w);
        return ((w + 7) / 8) * 8;
    endfunction

    // bits needed to hold the largest check count
    function automatic int rfield_w(input int rmax);
        return $clog2(rmax + 1);
    endfunction

    // total control word width for a variant
    function automatic int ctl_w(input int sw, input int rmax, input bit var_r);
        return var_r ? pad8(sw) + pad8(rfield_w(rmax)) : pad8(sw);
    endfunction

    // upper legal check count
    function automatic int rcap(input int rmax);
        return (rmax < 256) ? rmax : 256;
    endfunction

endpackage

// File: rtl/seq_unpack.sv
module seq_unpack #(
    parameter int SYM_W    = 8,
    parameter int RCHK_MAX = 16,
    parameter bit VAR_R    = 1'b1,
    localparam int RW   = seq_pkg::rfield_w(RCHK_MAX),
    localparam int NPAD = seq_pkg::pad8(SYM_W),
    localparam int RPAD = seq_pkg::pad8(RW),
    localparam int CW   = seq_pkg::ctl_w(SYM_W, RCHK_MAX, VAR_R)
) (
    input  logic [CW-1:0]    word,
    output logic [SYM_W-1:0] f_n,
    output logic [SYM_W-1:0] f_k,
    output logic [RW-1:0]    f_r,
    output logic             f_bad
);
    assign f_n = word[SYM_W-1:0];

    generate
        if (NPAD > SYM_W) begin : g_npad
            logic unused_npad;
            assign unused_npad = ^word[NPAD-1:SYM_W];
        end

        if (VAR_R) begin : g_var
            logic [RW-1:0] rf;
            assign rf = word[NPAD+RW-1:NPAD];
            if (RPAD > RW) begin : g_rpad
                logic unused_rpad;
                assign unused_rpad = ^word[NPAD+RPAD-1:NPAD+RW];
            end
            assign f_r   = rf;
            assign f_k   = f_n - SYM_W'(rf);
            assign f_bad = (f_n < SYM_W'(4)) || (rf < RW'(2))
                         || (32'(rf) > seq_pkg::rcap(RCHK_MAX));
        end else begin : g_fix
            assign f_r   = RW'(RCHK_MAX);
            assign f_k   = f_n - SYM_W'(RCHK_MAX);
            assign f_bad = (f_n < SYM_W'(4));
        end
    endgenerate
endmodule

// File: rtl/seq_fifo.sv
module seq_fifo #(
    parameter int W     = 21,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic [AW:0]  level;

    assign level = wp - rp;
    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign rdata = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp[AW-1:0]] <= wdata;
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    a_r3_level_bound: assert property (@(posedge clk) disable iff (rst)
        32'(level) <= DEPTH);
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/seq_block.sv
module seq_block
    import seq_pkg::*;
#(
    parameter int SYM_W = 8,
    parameter int RW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din_valid,
    input  logic             q_empty,
    input  logic [SYM_W-1:0] hd_n,
    input  logic [SYM_W-1:0] hd_k,
    input  logic [RW-1:0]    hd_r,
    output logic             q_pop,
    output logic             din_ready,
    output logic             open,
    output logic [SYM_W-1:0] o_n,
    output logic [SYM_W-1:0] o_k,
    output logic [RW-1:0]    o_r
);
    blk_state_e       st;
    logic [SYM_W-1:0] left;
    logic [SYM_W-1:0] cur_n, cur_k;
    logic [RW-1:0]    cur_r;
    logic             take;

    assign din_ready = (st == ST_OPEN) || !q_empty;
    assign take      = din_valid && din_ready;
    assign q_pop     = take && (st == ST_IDLE);
    assign open      = (st == ST_OPEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            left  <= '0;
            cur_n <= '0;
            cur_k <= '0;
            cur_r <= '0;
        end else if (q_pop) begin
            cur_n <= hd_n;
            cur_k <= hd_k;
            cur_r <= hd_r;
            left  <= hd_k - SYM_W'(1);
            st    <= (hd_k > SYM_W'(1)) ? ST_OPEN : ST_IDLE;
        end else if (take) begin
            left <= left - SYM_W'(1);
            if (left == SYM_W'(1)) st <= ST_IDLE;
        end
    end

    // the first symbol sees the queue head; later symbols see the held copy
    assign o_n = open ? cur_n : hd_n;
    assign o_k = open ? cur_k : hd_k;
    assign o_r = open ? cur_r : hd_r;

    a_r8_hold_settings: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPEN) |=> ($stable(cur_n) && $stable(cur_k) && $stable(cur_r)));
    a_r7_open_has_work: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPEN) |-> (left != '0));
endmodule

// File: rtl/blkparam_seq.sv
module blkparam_seq #(
    parameter int SYM_W    = 8,
    parameter int RCHK_MAX = 16,
    parameter bit VAR_R    = 1'b1,
    parameter int DEPTH    = 16,
    localparam int RW = seq_pkg::rfield_w(RCHK_MAX),
    localparam int CW = seq_pkg::ctl_w(SYM_W, RCHK_MAX, VAR_R),
    localparam int QW = 2 * SYM_W + RW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_valid,
    output logic             ctl_ready,
    input  logic [CW-1:0]    ctl_data,
    input  logic             din_valid,
    output logic             din_ready,
    output logic             blk_open,
    output logic [SYM_W-1:0] blk_n,
    output logic [SYM_W-1:0] blk_k,
    output logic [RW-1:0]    blk_r,
    output logic             ctl_bad
);
    logic [SYM_W-1:0] w_n, w_k, h_n, h_k;
    logic [RW-1:0]    w_r, h_r;
    logic             w_bad;
    logic             q_full, q_empty, q_push, q_pop;
    logic [QW-1:0]    q_rd;

    seq_unpack #(.SYM_W(SYM_W), .RCHK_MAX(RCHK_MAX), .VAR_R(VAR_R)) u_unpack (
        .word (ctl_data),
        .f_n  (w_n),
        .f_k  (w_k),
        .f_r  (w_r),
        .f_bad(w_bad)
    );

    assign ctl_ready = !q_full;
    assign q_push    = ctl_valid && !q_full;

    seq_fifo #(.W(QW), .DEPTH(DEPTH)) u_queue (
        .clk  (clk),
        .rst  (rst),
        .push (q_push),
        .wdata({w_n, w_k, w_r}),
        .pop  (q_pop),
        .rdata(q_rd),
        .full (q_full),
        .empty(q_empty)
    );

    assign {h_n, h_k, h_r} = q_rd;

    seq_block #(.SYM_W(SYM_W), .RW(RW)) u_block (
        .clk      (clk),
        .rst      (rst),
        .din_valid(din_valid),
        .q_empty  (q_empty),
        .hd_n     (h_n),
        .hd_k     (h_k),
        .hd_r     (h_r),
        .q_pop    (q_pop),
        .din_ready(din_ready),
        .open     (blk_open),
        .o_n      (blk_n),
        .o_k      (blk_k),
        .o_r      (blk_r)
    );

    always_ff @(posedge clk) begin
        if (rst)                  ctl_bad <= 1'b0;
        else if (q_push && w_bad) ctl_bad <= 1'b1;
    end

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        ctl_bad |=> ctl_bad);
    a_r9_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_bad) |-> $past(ctl_valid && ctl_ready));
endmodule

// File: tb/sim_blkparam_seq.sv
module seq_ref #(
    parameter int    SYM_W = 8,
    parameter int    RMAX  = 16,
    parameter bit    VAR_R = 1'b1,
    parameter int    CW    = 16,
    parameter int    NOFF  = 8,
    parameter int    RBITS = 5,
    parameter string TAG   = "R5"
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_valid,
    input  logic [CW-1:0] ctl_data,
    input  logic          din_valid,
    input  logic          ctl_ready,
    input  logic          din_ready,
    input  logic          blk_open,
    input  logic [7:0]    blk_n,
    input  logic [7:0]    blk_k,
    input  logic [4:0]    blk_r,
    input  logic          ctl_bad,
    output int            checks,
    output int            fails
);
    int qn[$];
    int qk[$];
    int qr[$];
    int open_m = 0;
    int left_m = 0;
    int cn = 0, ck = 0, cr = 0;
    int bad_m = 0;
    int msk;

    initial begin
        checks = 0;
        fails  = 0;
        msk    = (1 << SYM_W) - 1;
    end

    always @(posedge clk) begin : step_model
        int n, r, k;
        bit dacc, cacc;
        if (rst) begin
            qn.delete(); qk.delete(); qr.delete();
            open_m = 0;
            left_m = 0;
            bad_m  = 0;
        end else begin
            dacc = din_valid && (open_m != 0 || qn.size() > 0);
            cacc = ctl_valid && (qn.size() < 16);
            if (dacc && open_m == 0) begin
                cn = qn.pop_front();
                ck = qk.pop_front();
                cr = qr.pop_front();
                if (ck > 1) begin
                    open_m = 1;
                    left_m = ck - 1;
                end
            end else if (dacc) begin
                left_m = left_m - 1;
                if (left_m == 0) open_m = 0;
            end
            if (cacc) begin
                n = int'(ctl_data) & msk;
                r = VAR_R ? ((int'(ctl_data) >> NOFF) & ((1 << RBITS) - 1)) : RMAX;
                k = (n - r) & msk;
                if (n < 4 || (VAR_R && (r < 2 || r > RMAX))) bad_m = 1;
                qn.push_back(n);
                qk.push_back(k);
                qr.push_back(r);
            end
        end
    end

    task automatic cmp(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            cmp(int'(ctl_ready), (qn.size() < 16) ? 1 : 0, "R3", "ctl_ready");
            cmp(int'(din_ready), (open_m != 0 || qn.size() > 0) ? 1 : 0, "R4", "din_ready");
            cmp(int'(blk_open), open_m, "R7", "blk_open");
            cmp(int'(ctl_bad), bad_m, "R9", "ctl_bad");
            if (open_m != 0) begin
                cmp(int'(blk_n), cn, TAG, "blk_n");
                cmp(int'(blk_k), ck, TAG, "blk_k");
                cmp(int'(blk_r), cr, TAG, "blk_r");
            end else if (qn.size() > 0) begin
                cmp(int'(blk_n), qn[0], TAG, "blk_n");
                cmp(int'(blk_k), qk[0], TAG, "blk_k");
                cmp(int'(blk_r), qr[0], TAG, "blk_r");
            end
        end
    end
endmodule

module sim_blkparam_seq;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        cv  = 1'b0;
    logic        dv  = 1'b0;
    logic [15:0] cd  = '0;

    logic       c0_rdy, d0_rdy, o0, b0;
    logic [7:0] n0, k0;
    logic [4:0] r0;
    logic       c1_rdy, d1_rdy, o1, b1;
    logic [7:0] n1, k1;
    logic [4:0] r1;

    int m0_chk, m0_fail, m1_chk, m1_fail;
    int tchk = 0, tfail = 0;
    bit wd_fired = 1'b0;

    blkparam_seq u0 (
        .clk(clk), .rst(rst), .ctl_valid(cv), .ctl_ready(c0_rdy), .ctl_data(cd),
        .din_valid(dv), .din_ready(d0_rdy), .blk_open(o0),
        .blk_n(n0), .blk_k(k0), .blk_r(r0), .ctl_bad(b0)
    );

    blkparam_seq #(.VAR_R(1'b0)) u1 (
        .clk(clk), .rst(rst), .ctl_valid(cv), .ctl_ready(c1_rdy), .ctl_data(cd[7:0]),
        .din_valid(dv), .din_ready(d1_rdy), .blk_open(o1),
        .blk_n(n1), .blk_k(k1), .blk_r(r1), .ctl_bad(b1)
    );

    seq_ref #(.VAR_R(1'b1), .CW(16), .TAG("R2 R5 R8 R11")) m0 (
        .clk(clk), .rst(rst), .ctl_valid(cv), .ctl_data(cd), .din_valid(dv),
        .ctl_ready(c0_rdy), .din_ready(d0_rdy), .blk_open(o0),
        .blk_n(n0), .blk_k(k0), .blk_r(r0), .ctl_bad(b0),
        .checks(m0_chk), .fails(m0_fail)
    );

    seq_ref #(.VAR_R(1'b0), .CW(8), .TAG("R6 R8 R11")) m1 (
        .clk(clk), .rst(rst), .ctl_valid(cv), .ctl_data(cd[7:0]), .din_valid(dv),
        .ctl_ready(c1_rdy), .din_ready(d1_rdy), .blk_open(o1),
        .blk_n(n1), .blk_k(k1), .blk_r(r1), .ctl_bad(b1),
        .checks(m1_chk), .fails(m1_fail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tchk++;
        if (!ok) begin
            tfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic push_word(input int n, input int r, input int pad);
        cv = 1'b1;
        cd = {3'(pad), 5'(r), 8'(n)};
        step();
        cv = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cv  = 1'b0;
        dv  = 1'b0;
        step();
        step();
    endtask

    task automatic scenario();
        // R1: values seen under reset
        do_reset();
        chk(c0_rdy == 1'b1, "R1 ctl_ready", int'(c0_rdy), 1);
        chk(d0_rdy == 1'b0, "R1 din_ready", int'(d0_rdy), 0);
        chk(b0 == 1'b0, "R1 ctl_bad", int'(b0), 0);
        chk(d1_rdy == 1'b0, "R1 din_ready fixed", int'(d1_rdy), 0);
        rst = 1'b0;
        step();
        chk(c0_rdy == 1'b1 && d0_rdy == 1'b0, "R1 after release", int'(d0_rdy), 0);

        // R4: starved data input stays stalled
        dv = 1'b1;
        repeat (5) step();
        chk(d0_rdy == 1'b0, "R4 stall without word", int'(d0_rdy), 0);
        dv = 1'b0;

        // R4: one word makes ready rise the next cycle
        push_word(30, 4, 0);
        chk(d0_rdy == 1'b1, "R4 ready after word", int'(d0_rdy), 1);
        chk(n0 == 8'd30 && k0 == 8'd26 && r0 == 5'd4, "R5 first settings", int'(k0), 26);
        chk(k1 == 8'd14 && r1 == 5'd16, "R6 fixed settings", int'(k1), 14);
        dv = 1'b1;
        repeat (40) step();
        dv = 1'b0;

        // R10 + R3: reset clears, then fill the queue with padded words (R2)
        do_reset();
        rst = 1'b0;
        step();
        for (int i = 0; i < 16; i++) push_word(20 + i, 2 + (i % 15), 5);
        chk(c0_rdy == 1'b0, "R3 full variable", int'(c0_rdy), 0);
        chk(c1_rdy == 1'b0, "R3 full fixed", int'(c1_rdy), 0);
        chk(n0 == 8'd20 && r0 == 5'd2, "R2 R11 head after padding", int'(n0), 20);
        push_word(50, 9, 7);
        chk(c0_rdy == 1'b0, "R3 extra word refused", int'(c0_rdy), 0);

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            dv = ($urandom % 4) != 0;
            cv = ($urandom % 3) == 0;
            cd = {3'($urandom), 5'(2 + $urandom % 15), 8'(20 + $urandom % 60)};
            step();
        end
        cv = 1'b0;
        dv = 1'b1;
        repeat (1500) step();
        dv = 1'b0;
        chk(o0 == 1'b0 && d0_rdy == 1'b0, "R7 drained", int'(d0_rdy), 0);

        // R9: range checks and stickiness
        chk(b0 == 1'b0, "R9 clean before", int'(b0), 0);
        push_word(30, 1, 0);
        chk(b0 == 1'b1, "R9 check below two", int'(b0), 1);
        chk(b1 == 1'b0, "R9 fixed ignores check field", int'(b1), 0);
        repeat (5) step();
        chk(b0 == 1'b1, "R9 sticky", int'(b0), 1);
        push_word(2, 5, 0);
        chk(b1 == 1'b1, "R9 short length fixed", int'(b1), 1);

        // R10: reset clears flag and queue
        do_reset();
        rst = 1'b0;
        step();
        chk(b0 == 1'b0 && b1 == 1'b0, "R10 flag cleared", int'(b0), 0);
        chk(c0_rdy == 1'b1 && d0_rdy == 1'b0, "R10 queue empty", int'(d0_rdy), 0);

        // R9 boundaries
        push_word(4, 2, 0);
        chk(b0 == 1'b0, "R9 lowest legal values", int'(b0), 0);
        push_word(40, 16, 0);
        chk(b0 == 1'b0, "R9 highest legal check", int'(b0), 0);
        push_word(40, 17, 0);
        chk(b0 == 1'b1, "R9 check above limit", int'(b0), 1);
        repeat (4) step();
    endtask

    initial begin
        fork
            scenario();
            begin
                repeat (100000) @(posedge clk);
                wd_fired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_fired) begin
            tchk++;
            tfail++;
            $display("FAIL watchdog expired");
        end
        $display("TB_RESULT checks=%0d failures=%0d",
                 tchk + m0_chk + m1_chk, tfail + m0_fail + m1_fail);
        $finish;
    end
endmodule